// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory Engine

This block is the memory-side directory controller of one home node in a shared-memory multiprocessor. For every memory block homed at the node it keeps a coherence state, a small set of sharer pointers and an acknowledgment counter. Caches send request messages (read, write, replace-modified, update, invalidate acknowledgment). The engine replies with read data, write data, busy or invalidate messages and walks each block through its four states.

Every entry has a fixed number of hardware pointer slots, each with a valid bit, and a separate one-bit pointer for the home node itself. Because of that bit, reads from the home node never need a slot. A new read from a remote cache that finds every slot in use is not serviced. The engine raises a one-cycle divert pulse so that software can take over, and it leaves the entry as it was. The engine takes at most one message per cycle and emits at most one per cycle. When the output is stalled it holds its input, so no message is lost.

Top module: `coh_dir_engine`

## Requirements
- R1: After reset every entry is Shared with an empty sharer set and counter 0, `out_valid` and `divert` are 0 and `in_ready` is 1.
- R2: A read (in_op 0) to a Shared entry from a remote cache that is not yet a sharer stores it in the lowest free slot and returns read data (out_op 0) to it. A read from a cache that already holds the block returns read data and takes no new slot.
- R3: A write (in_op 1) to a Shared entry whose set is empty, or holds only the writer, makes the writer the sole owner (Owned state) and returns write data (out_op 1) to it.
- R4: A write to a Shared entry that has other sharers loads the counter with the number of other sharers. It sends an invalidate (out_op 2) to each of them, one per cycle: slots in ascending order first, then the home node when its bit is set. `in_ready` stays 0 until the last one has been sent.
- R5: In the write-pending state, an acknowledgment (in_op 4) decrements a counter above 1 and produces no output. An acknowledgment at counter 1, or an update (in_op 3), clears the counter, sends write data to the new owner and enters Owned.
- R6: A read or write from a cache other than the owner of an Owned entry sends one invalidate to the old owner and makes the requester the sole pointer. A write enters write-pending; a read enters read-pending. In read-pending, an acknowledgment or update sends read data to the requester and returns the entry to Shared.
- R7: Replace-modified (in_op 2) from the owner of an Owned entry empties the set, returns the entry to Shared and produces no output.
- R8: In either pending state, reads and writes are answered with busy (out_op 3) to the sender, and replace-modified messages are ignored with no output.
- R9: A remote read that is not yet a sharer and reaches a Shared entry with all slots in use raises `divert` for one cycle. It produces no output message and leaves the sharer set unchanged.
- R10: Reads from the home node (node HOME_NODE, default 0) set the home bit, never use a slot and never divert.
- R11: While `out_valid` is 1 and `out_ready` is 0, the output message is held unchanged and `in_ready` is 0. Messages are delivered in acceptance order once `out_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request message present |
| in_ready | output | 1 | Engine takes the request at this edge |
| in_op | input | 3 | Request opcode: 0 read, 1 write, 2 replace-modified, 3 update, 4 acknowledgment |
| in_src | input | NODE_W | Sending node |
| in_addr | input | ADDR_W | Block address (directory index) |
| out_valid | output | 1 | Output message present |
| out_ready | input | 1 | Receiver takes the output message |
| out_op | output | 2 | Output opcode: 0 read data, 1 write data, 2 invalidate, 3 busy |
| out_dst | output | NODE_W | Destination node |
| out_addr | output | ADDR_W | Block address |
| divert | output | 1 | One-cycle pulse: a read overflowed the pointer slots |

## Verification
The hardest condition to reach from the ports is a write that fans out invalidates to every slot and to the home bit together. The engine then waits for the full count of acknowledgments. Reaching it needs a long prelude: enough distinct remote readers to fill every slot, an overflowing sixth reader whose absence must then show up in the invalidate list, a home-node read, and a duplicate read. Only after that does the write arrive, followed by the matching run of acknowledgments. The stimulus builds this prelude in a directed sequence after the vector table has exercised each single-step transition.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  typedef enum logic [2:0] {
    REQ_RD   = 3'd0,
    REQ_WR   = 3'd1,
    REQ_REPM = 3'd2,
    REQ_UPD  = 3'd3,
    REQ_ACK  = 3'd4
  } req_op_e;

  typedef enum logic [1:0] {
    RSP_RDATA = 2'd0,
    RSP_WDATA = 2'd1,
    RSP_INV   = 2'd2,
    RSP_BUSY  = 2'd3
  } rsp_op_e;

  typedef enum logic [1:0] {
    DS_SHARED  = 2'd0,
    DS_OWNED   = 2'd1,
    DS_RD_PEND = 2'd2,
    DS_WR_PEND = 2'd3
  } dstate_e;

endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store #(
  parameter int NODE_W = 4,
  parameter int ADDR_W = 4,
  parameter int NPTR   = 5,
  parameter int CNT_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   we,
  input  logic [1:0]             wr_st,
  input  logic [NPTR-1:0]        wr_vld,
  input  logic [NPTR*NODE_W-1:0] wr_ptr,
  input  logic                   wr_loc,
  input  logic [CNT_W-1:0]       wr_cnt,
  output logic [1:0]             rd_st,
  output logic [NPTR-1:0]        rd_vld,
  output logic [NPTR*NODE_W-1:0] rd_ptr,
  output logic                   rd_loc,
  output logic [CNT_W-1:0]       rd_cnt
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [1:0]             st_m  [DEPTH];
  logic [NPTR-1:0]        vld_m [DEPTH];
  logic [NPTR*NODE_W-1:0] ptr_m [DEPTH];
  logic                   loc_m [DEPTH];
  logic [CNT_W-1:0]       cnt_m [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        st_m[e]  <= 2'd0;
        vld_m[e] <= '0;
        ptr_m[e] <= '0;
        loc_m[e] <= 1'b0;
        cnt_m[e] <= '0;
      end
    end else if (we) begin
      st_m[addr]  <= wr_st;
      vld_m[addr] <= wr_vld;
      ptr_m[addr] <= wr_ptr;
      loc_m[addr] <= wr_loc;
      cnt_m[addr] <= wr_cnt;
    end
  end

  assign rd_st  = st_m[addr];
  assign rd_vld = vld_m[addr];
  assign rd_ptr = ptr_m[addr];
  assign rd_loc = loc_m[addr];
  assign rd_cnt = cnt_m[addr];
endmodule

// File: rtl/coh_dir_decide.sv
module coh_dir_decide
  import coh_dir_pkg::*;
#(
  parameter int NODE_W    = 4,
  parameter int NPTR      = 5,
  parameter int CNT_W     = 3,
  parameter int HOME_NODE = 0
) (
  input  logic [2:0]             op,
  input  logic [NODE_W-1:0]      src,
  input  logic [1:0]             st,
  input  logic [NPTR-1:0]        vld,
  input  logic [NPTR*NODE_W-1:0] ptr,
  input  logic                   loc,
  input  logic [CNT_W-1:0]       cnt,
  output logic [1:0]             n_st,
  output logic [NPTR-1:0]        n_vld,
  output logic [NPTR*NODE_W-1:0] n_ptr,
  output logic                   n_loc,
  output logic [CNT_W-1:0]       n_cnt,
  output logic                   rsp_v,
  output logic [1:0]             rsp_op,
  output logic [NODE_W-1:0]      rsp_dst,
  output logic [NPTR-1:0]        inv_mask,
  output logic                   inv_loc,
  output logic                   dv,
  output logic                   busy_ev
);
  localparam logic [NODE_W-1:0] HOME = NODE_W'(HOME_NODE);

  function automatic int count_set(input logic [NPTR-1:0] m);
    int c = 0;
    for (int k = 0; k < NPTR; k++) c += int'(m[k]);
    return c;
  endfunction

  logic            src_home;
  logic [NPTR-1:0] hit;
  logic            src_in;
  int              free_idx;
  int              own_idx;
  logic [NODE_W-1:0] owner;
  logic [CNT_W-1:0]  others;

  always_comb begin
    src_home = (src == HOME);
    for (int k = 0; k < NPTR; k++)
      hit[k] = vld[k] && !src_home && (ptr[k*NODE_W +: NODE_W] == src);
    src_in = src_home ? loc : |hit;
    free_idx = 0;
    own_idx  = 0;
    for (int k = NPTR - 1; k >= 0; k--) begin
      if (!vld[k]) free_idx = k;
      if (vld[k])  own_idx  = k;
    end
    owner  = (vld == '0) ? HOME : ptr[own_idx*NODE_W +: NODE_W];
    others = CNT_W'(count_set(vld) + int'(loc) - int'(src_in));
  end

  always_comb begin
    n_st = st; n_vld = vld; n_ptr = ptr; n_loc = loc; n_cnt = cnt;
    rsp_v = 1'b0; rsp_op = RSP_RDATA; rsp_dst = src;
    inv_mask = '0; inv_loc = 1'b0; dv = 1'b0; busy_ev = 1'b0;
    unique case (dstate_e'(st))
      DS_SHARED: begin
        if (op == REQ_RD) begin
          if (src_home) begin
            n_loc = 1'b1; rsp_v = 1'b1;
          end else if (src_in) begin
            rsp_v = 1'b1;
          end else if (&vld) begin
            dv = 1'b1;
          end else begin
            n_vld[free_idx] = 1'b1;
            n_ptr[free_idx*NODE_W +: NODE_W] = src;
            rsp_v = 1'b1;
          end
        end else if (op == REQ_WR) begin
          n_vld = '0; n_loc = src_home;
          if (!src_home) begin n_vld[0] = 1'b1; n_ptr[NODE_W-1:0] = src; end
          if (others == '0) begin
            n_st = DS_OWNED; rsp_v = 1'b1; rsp_op = RSP_WDATA;
          end else begin
            n_st = DS_WR_PEND; n_cnt = others;
            inv_mask = vld & ~hit;
            inv_loc  = loc && !src_home;
          end
        end
      end
      DS_OWNED: begin
        if ((op == REQ_RD || op == REQ_WR) && src != owner) begin
          n_vld = '0; n_loc = src_home;
          if (!src_home) begin n_vld[0] = 1'b1; n_ptr[NODE_W-1:0] = src; end
          n_cnt = CNT_W'(1);
          n_st = (op == REQ_WR) ? DS_WR_PEND : DS_RD_PEND;
          inv_mask = vld; inv_loc = loc;
        end else if (op == REQ_RD || op == REQ_WR) begin
          rsp_v = 1'b1; rsp_op = (op == REQ_WR) ? RSP_WDATA : RSP_RDATA;
        end else if (op == REQ_REPM && src == owner) begin
          n_vld = '0; n_loc = 1'b0; n_st = DS_SHARED;
        end
      end
      DS_WR_PEND, DS_RD_PEND: begin
        if (op == REQ_RD || op == REQ_WR) begin
          rsp_v = 1'b1; rsp_op = RSP_BUSY; busy_ev = 1'b1;
        end else if ((op == REQ_ACK && cnt > CNT_W'(1)) && st == DS_WR_PEND) begin
          n_cnt = cnt - CNT_W'(1);
        end else if (op == REQ_ACK || op == REQ_UPD) begin
          n_cnt = '0; rsp_v = 1'b1; rsp_dst = owner;
          if (st == DS_WR_PEND) begin n_st = DS_OWNED;  rsp_op = RSP_WDATA; end
          else                  begin n_st = DS_SHARED; rsp_op = RSP_RDATA; end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_dir_emit.sv
module coh_dir_emit
  import coh_dir_pkg::*;
#(
  parameter int NODE_W    = 4,
  parameter int ADDR_W    = 4,
  parameter int NPTR      = 5,
  parameter int HOME_NODE = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc,
  input  logic                   rsp_v,
  input  logic [1:0]             rsp_op,
  input  logic [NODE_W-1:0]      rsp_dst,
  input  logic [ADDR_W-1:0]      ld_addr,
  input  logic [NPTR-1:0]        ld_mask,
  input  logic                   ld_loc,
  input  logic [NPTR*NODE_W-1:0] ld_ptr,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [1:0]             out_op,
  output logic [NODE_W-1:0]      out_dst,
  output logic [ADDR_W-1:0]      out_addr,
  output logic                   slot_free,
  output logic                   q_busy
);
  logic [NPTR-1:0]        q_mask;
  logic                   q_loc;
  logic [NPTR*NODE_W-1:0] q_ptr;
  logic [ADDR_W-1:0]      q_addr;
  int                     lo;

  always_comb begin
    lo = 0;
    for (int k = NPTR - 1; k >= 0; k--) if (q_mask[k]) lo = k;
  end

  assign slot_free = !out_valid || out_ready;
  assign q_busy    = (|q_mask) || q_loc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_op <= '0; out_dst <= '0; out_addr <= '0;
      q_mask <= '0; q_loc <= 1'b0; q_ptr <= '0; q_addr <= '0;
    end else begin
      if (slot_free) begin
        out_valid <= 1'b0;
        if (|q_mask) begin
          out_valid <= 1'b1; out_op <= RSP_INV; out_addr <= q_addr;
          out_dst <= q_ptr[lo*NODE_W +: NODE_W];
          q_mask[lo] <= 1'b0;
        end else if (q_loc) begin
          out_valid <= 1'b1; out_op <= RSP_INV; out_addr <= q_addr;
          out_dst <= NODE_W'(HOME_NODE);
          q_loc <= 1'b0;
        end else if (acc && rsp_v) begin
          out_valid <= 1'b1; out_op <= rsp_op; out_dst <= rsp_dst;
          out_addr <= ld_addr;
        end
      end
      if (acc) begin
        q_mask <= ld_mask; q_loc <= ld_loc; q_ptr <= ld_ptr; q_addr <= ld_addr;
      end
    end
  end

  // R11
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_op) && $stable(out_dst) && $stable(out_addr));

  // R4
  inv_one_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $countones(q_mask) + 1 >= $countones($past(q_mask)));
endmodule

// File: rtl/coh_dir_engine.sv
module coh_dir_engine
  import coh_dir_pkg::*;
#(
  parameter int NODE_W    = 4,
  parameter int ADDR_W    = 4,
  parameter int NPTR      = 5,
  parameter int HOME_NODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [NODE_W-1:0] in_src,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_op,
  output logic [NODE_W-1:0] out_dst,
  output logic [ADDR_W-1:0] out_addr,
  output logic              divert
);
  localparam int CNT_W = $clog2(NPTR + 2);

  logic [1:0]             e_st, n_st;
  logic [NPTR-1:0]        e_vld, n_vld, inv_mask;
  logic [NPTR*NODE_W-1:0] e_ptr, n_ptr;
  logic                   e_loc, n_loc, inv_loc;
  logic [CNT_W-1:0]       e_cnt, n_cnt;
  logic                   rsp_v, dv, busy_ev, slot_free, q_busy, acc;
  logic [1:0]             rsp_op;
  logic [NODE_W-1:0]      rsp_dst;

  assign in_ready = slot_free && !q_busy;
  assign acc      = in_valid && in_ready;

  coh_dir_store #(.NODE_W(NODE_W), .ADDR_W(ADDR_W), .NPTR(NPTR), .CNT_W(CNT_W)) store_i (
    .clk(clk), .rst_n(rst_n), .addr(in_addr), .we(acc),
    .wr_st(n_st), .wr_vld(n_vld), .wr_ptr(n_ptr), .wr_loc(n_loc), .wr_cnt(n_cnt),
    .rd_st(e_st), .rd_vld(e_vld), .rd_ptr(e_ptr), .rd_loc(e_loc), .rd_cnt(e_cnt));

  coh_dir_decide #(.NODE_W(NODE_W), .NPTR(NPTR), .CNT_W(CNT_W), .HOME_NODE(HOME_NODE)) decide_i (
    .op(in_op), .src(in_src), .st(e_st), .vld(e_vld), .ptr(e_ptr), .loc(e_loc), .cnt(e_cnt),
    .n_st(n_st), .n_vld(n_vld), .n_ptr(n_ptr), .n_loc(n_loc), .n_cnt(n_cnt),
    .rsp_v(rsp_v), .rsp_op(rsp_op), .rsp_dst(rsp_dst),
    .inv_mask(inv_mask), .inv_loc(inv_loc), .dv(dv), .busy_ev(busy_ev));

  coh_dir_emit #(.NODE_W(NODE_W), .ADDR_W(ADDR_W), .NPTR(NPTR), .HOME_NODE(HOME_NODE)) emit_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .rsp_v(rsp_v), .rsp_op(rsp_op), .rsp_dst(rsp_dst),
    .ld_addr(in_addr), .ld_mask(inv_mask), .ld_loc(inv_loc), .ld_ptr(e_ptr),
    .out_ready(out_ready), .out_valid(out_valid), .out_op(out_op), .out_dst(out_dst),
    .out_addr(out_addr), .slot_free(slot_free), .q_busy(q_busy));

  always_ff @(posedge clk) begin
    if (!rst_n) divert <= 1'b0;
    else        divert <= acc && dv;
  end

  // R9
  divert_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    divert |-> !out_valid);

  // R9
  divert_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    divert |-> $past(in_op) == 3'd0);

  // R8
  busy_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && busy_ev |=> out_valid && out_op == 2'd3 && out_dst == $past(in_src));

  // R5
  ack_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> int'(n_cnt) <= NPTR + 1);
endmodule

// File: tb/coh_dir_engine_tb_top.sv
module coh_dir_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1, divert;
  logic [2:0] in_op = '0;
  logic [3:0] in_src = '0, in_addr = '0, out_dst, out_addr;
  logic [1:0] out_op;

  always #5 clk = ~clk;

  coh_dir_engine dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src(in_src), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
    .out_dst(out_dst), .out_addr(out_addr), .divert(divert));

  int total = 0, bad = 0, mon_n = 0, rd_idx = 0, div_n = 0;
  logic [1:0] mon_op [256];
  logic [3:0] mon_dst [256];
  logic [3:0] mon_addr [256];
  bit done = 0;

  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready && mon_n < 256) begin
      mon_op[mon_n] <= out_op; mon_dst[mon_n] <= out_dst; mon_addr[mon_n] <= out_addr;
      mon_n <= mon_n + 1;
    end
    if (rst_n && divert) div_n <= div_n + 1;
  end

  // vector: {op, src, addr, has_msg, msg_op, msg_dst}
  localparam int NV = 14;
  localparam logic [17:0] VECS [NV] = '{
    {3'd0, 4'd1, 4'd1, 1'b1, 2'd0, 4'd1},  // R2 read, new sharer
    {3'd0, 4'd2, 4'd1, 1'b1, 2'd0, 4'd2},  // R2 second sharer
    {3'd1, 4'd3, 4'd2, 1'b1, 2'd1, 4'd3},  // R3 / R1 write to fresh entry
    {3'd0, 4'd4, 4'd2, 1'b1, 2'd2, 4'd3},  // R6 read hits owned -> inv owner
    {3'd0, 4'd5, 4'd2, 1'b1, 2'd3, 4'd5},  // R8 busy in read-pending
    {3'd2, 4'd3, 4'd2, 1'b0, 2'd0, 4'd0},  // R8 replace ignored
    {3'd4, 4'd3, 4'd2, 1'b1, 2'd0, 4'd4},  // R6 ack completes read
    {3'd1, 4'd4, 4'd2, 1'b1, 2'd1, 4'd4},  // R3 write, set holds only writer
    {3'd2, 4'd4, 4'd2, 1'b0, 2'd0, 4'd0},  // R7 replace from owner
    {3'd1, 4'd6, 4'd2, 1'b1, 2'd1, 4'd6},  // R7 set now empty
    {3'd1, 4'd7, 4'd2, 1'b1, 2'd2, 4'd6},  // R6 write hits owned -> inv
    {3'd1, 4'd8, 4'd2, 1'b1, 2'd3, 4'd8},  // R8 busy in write-pending
    {3'd3, 4'd6, 4'd2, 1'b1, 2'd1, 4'd7},  // R5 update completes write
    {3'd0, 4'd0, 4'd3, 1'b1, 2'd0, 4'd0}   // R10 home read
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic send(input logic [2:0] op, input logic [3:0] src, input logic [3:0] addr);
    in_op = op; in_src = src; in_addr = addr; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_expect(input logic [1:0] op, input logic [3:0] dst,
                            input logic [3:0] addr, input string req);
    if (rd_idx >= mon_n) begin
      chk(0, req, -1, int'({op, dst}));
    end else begin
      chk(mon_op[rd_idx] == op && mon_dst[rd_idx] == dst && mon_addr[rd_idx] == addr, req,
          int'({mon_op[rd_idx], mon_dst[rd_idx], mon_addr[rd_idx]}), int'({op, dst, addr}));
      rd_idx++;
    end
  endtask

  task automatic expect_none(input string req);
    chk(mon_n == rd_idx, req, mon_n - rd_idx, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(divert == 1'b0, "R1 divert", int'(divert), 0);

    for (int v = 0; v < NV; v++) begin
      logic [17:0] w;
      w = VECS[v];
      send(w[17:15], w[14:11], w[10:7]);
      settle();
      if (w[6]) pop_expect(w[5:4], w[3:0], w[10:7], $sformatf("vector %0d", v));
      else      expect_none($sformatf("vector %0d no output", v));
    end

    // R4 / R5: addr1 holds {1,2}; add 3 and home, then node 2 writes
    send(3'd0, 4'd3, 4'd1); settle(); pop_expect(2'd0, 4'd3, 4'd1, "R2 third sharer");
    send(3'd0, 4'd0, 4'd1); settle(); pop_expect(2'd0, 4'd0, 4'd1, "R10 home read");
    send(3'd1, 4'd2, 4'd1);
    chk(in_ready == 1'b0, "R4 input held during invalidates", int'(in_ready), 0);
    settle();
    pop_expect(2'd2, 4'd1, 4'd1, "R4 inv slot0");
    pop_expect(2'd2, 4'd3, 4'd1, "R4 inv slot2");
    pop_expect(2'd2, 4'd0, 4'd1, "R4 inv home last");
    expect_none("R4 no extra inv");
    send(3'd4, 4'd1, 4'd1); settle(); expect_none("R5 ack 1 silent");
    send(3'd4, 4'd3, 4'd1); settle(); expect_none("R5 ack 2 silent");
    send(3'd4, 4'd0, 4'd1); settle(); pop_expect(2'd1, 4'd2, 4'd1, "R5 final ack");

    // R9 / R10: fill slots on addr4
    for (int s = 1; s <= 5; s++) begin
      send(3'd0, 4'(s), 4'd4); settle();
      pop_expect(2'd0, 4'(s), 4'd4, "R2 fill slot");
    end
    send(3'd0, 4'd6, 4'd4); settle();
    expect_none("R9 overflow read silent");
    chk(div_n == 1, "R9 divert pulse", div_n, 1);
    send(3'd0, 4'd0, 4'd4); settle();
    pop_expect(2'd0, 4'd0, 4'd4, "R10 home read when full");
    chk(div_n == 1, "R10 no divert for home", div_n, 1);
    send(3'd0, 4'd1, 4'd4); settle();
    pop_expect(2'd0, 4'd1, 4'd4, "R2 duplicate read");
    chk(div_n == 1, "R2 no divert on duplicate", div_n, 1);
    send(3'd1, 4'd7, 4'd4); settle();
    for (int s = 1; s <= 5; s++) pop_expect(2'd2, 4'(s), 4'd4, "R9 set unchanged inv");
    pop_expect(2'd2, 4'd0, 4'd4, "R4 home inv last");
    expect_none("R9 overflowed reader not invalidated");
    for (int a = 0; a < 5; a++) begin
      send(3'd4, 4'd1, 4'd4); settle();
    end
    expect_none("R5 five silent acks");
    send(3'd4, 4'd0, 4'd4); settle();
    pop_expect(2'd1, 4'd7, 4'd4, "R5 sixth ack");

    // R11 backpressure
    out_ready = 1'b0;
    send(3'd0, 4'd9, 4'd5);
    in_op = 3'd0; in_src = 4'd10; in_addr = 4'd5; in_valid = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(!in_ready && out_valid && out_dst == 4'd9 && out_op == 2'd0, "R11 hold",
          int'({in_ready, out_valid, out_dst}), int'({1'b0, 1'b1, 4'd9}));
    end
    out_ready = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    settle();
    pop_expect(2'd0, 4'd9, 4'd5, "R11 first after stall");
    pop_expect(2'd0, 4'd10, 4'd5, "R11 second after stall");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule